// File: doc/BRIEF.md
# SMRAM Access Control Decoder

This block holds the two configuration registers that govern access to system-management memory in a chipset: a control register and an extended control register. It also applies a lock that, once set, stays set until a hardware reset. A single-cycle write port loads the registers and a combinational readback port returns the register at the offset being addressed.

For every memory access the block gives a route decision: serve it from DRAM or pass it to the external bus. The decision depends on the access address, a flag that tells whether the processor is in management mode, the register contents and a top-of-memory input. There are three regions. The first is the legacy video window at 0xA0000. The second is an optional high alias of that window at 0x100A0000, which replaces it. The third is a segment of programmable size taken from the end of memory that only management mode may reach. An address outside all three goes to DRAM when it is below top-of-memory.

Top module: `smram_gate`

## Requirements
- R1: After reset the control register reads 8'h02 and the extended register reads 8'h00. With those values an access outside management mode to the legacy window 0xA0000–0xBFFFF routes to the external bus (route_dram = 0).
- R2: While the lock is clear, a write to offset 0x72 loads bits 6:3 of the control register from the data. Bits 7, 2 and 0 read 0 and bit 1 reads 1 whatever is written.
- R3: A write at offset 0x72 with data bit 4 set while unlocked sets the lock (control bit 4). In the same update it forces control bit 6 (open) to 0. The lock clears only on reset.
- R4: While locked, a write at offset 0x72 changes only control bit 5 (close). Every other bit keeps its value.
- R5: Outside management mode, an access inside the active window routes to DRAM only when control bits 6:4 equal 3'b100 (open=1, close=0, lock=0). Otherwise it routes to the external bus.
- R6: In management mode, an access inside the active window routes to DRAM exactly when control bit 3 (enable) is 1 and bit 5 (close) is 0.
- R7: When extended bit 7 is 1, the active window is 0x100A0000 up to but not including 0x10100000, and the legacy range falls back to the default rule.
- R8: When control bit 3 and extended bit 0 are both 1, a top segment of 128 KB shifted left by extended bits 2:1 ends at top-of-memory. Inside it an access routes to DRAM in management mode and to the external bus outside it.
- R9: While locked, writes at offset 0x73 are ignored. While unlocked, they store data bits 7:6 and 2:0. Extended bits 5:3 always read back as control bits 5:3.
- R10: An address outside every window and segment routes to DRAM when it is below top-of-memory and to the external bus at or above it.
- R11: Writes at any offset other than 0x72 and 0x73 change no register, and readback at such an offset returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cfg_we | input | 1 | Write strobe for one cycle |
| cfg_addr | input | 8 | Register offset for write and readback |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Readback of the register at cfg_addr |
| acc_addr | input | 32 | Address of the memory access being decoded |
| smm_mode | input | 1 | Processor is in management mode |
| tom | input | 32 | Top-of-memory byte address |
| route_dram | output | 1 | 1: serve from DRAM, 0: pass to the external bus |

## Verification
The hardest case to reach is a locked register set whose enable, close and extended fields hold useful values. Once the lock is set, only the close bit can change, so any other field must be loaded before the locking write. Each locked scenario therefore starts from a fresh reset, programs the extended register and the control fields while unlocked, and then sets the lock. It then tries to overwrite every field and reads back the result. Segment routing is tested in the same way, probing the last address below the segment, its first address, and top-of-memory itself, both inside and outside management mode.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int unsigned REG_W = 8;

    localparam logic [REG_W-1:0] CTRL_OFFSET = 8'h72;
    localparam logic [REG_W-1:0] EXT_OFFSET  = 8'h73;
    localparam logic [REG_W-1:0] CTRL_RESET  = 8'h02;

    // control register bit positions
    localparam int unsigned C_OPEN  = 6;
    localparam int unsigned C_CLOSE = 5;
    localparam int unsigned C_LOCK  = 4;
    localparam int unsigned C_EN    = 3;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [1:0]       ext_hi;   // extended bits 7:6
        logic [2:0]       ext_lo;   // extended bits 2:0
    } cfg_state_t;

endpackage

// File: rtl/smram_regs.sv
module smram_regs
    import smram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_off,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] ext_q
);

    cfg_state_t st_d, st_q;
    logic       locked;

    assign locked = st_q.ctrl[C_LOCK];

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_off == CTRL_OFFSET) begin
            if (locked) begin
                st_d.ctrl[C_CLOSE] = wr_data[C_CLOSE];
            end else begin
                st_d.ctrl[6:3] = wr_data[6:3];
                if (wr_data[C_LOCK]) begin
                    st_d.ctrl[C_OPEN] = 1'b0;
                end
            end
        end
        if (wr_en && wr_off == EXT_OFFSET && !locked) begin
            st_d.ext_hi = wr_data[7:6];
            st_d.ext_lo = wr_data[2:0];
        end
        // fixed bits
        st_d.ctrl[7] = 1'b0;
        st_d.ctrl[2] = 1'b0;
        st_d.ctrl[1] = 1'b1;
        st_d.ctrl[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: CTRL_RESET, ext_hi: 2'b00, ext_lo: 3'b000};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;
    assign ext_q  = {st_q.ext_hi, st_q.ctrl[5:3], st_q.ext_lo};

    always_comb begin
        unique case (wr_off)
            CTRL_OFFSET: rd_data = ctrl_q;
            EXT_OFFSET:  rd_data = ext_q;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/smram_window.sv
module smram_window #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,    // exclusive
    output logic              hit
);

    assign hit = (addr >= lo) && (addr < hi);

endmodule

// File: rtl/smram_route.sv
module smram_route
    import smram_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 32,
    parameter logic [ADDR_W-1:0]  LEGACY_BASE = 32'h000A_0000,
    parameter logic [ADDR_W-1:0]  LEGACY_SIZE = 32'h0002_0000,
    parameter logic [ADDR_W-1:0]  ALIAS_BASE  = 32'h100A_0000,
    parameter logic [ADDR_W-1:0]  ALIAS_SIZE  = 32'h0006_0000,
    parameter logic [ADDR_W-1:0]  SEG_UNIT    = 32'h0002_0000,
    parameter int unsigned        SEG_STEPS   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              smm,
    input  logic [ADDR_W-1:0] top,
    input  logic [REG_W-1:0]  ctrl,
    input  logic [REG_W-1:0]  ext,
    output logic              to_dram
);

    localparam int unsigned SEL_W = $clog2(SEG_STEPS);

    logic [ADDR_W-1:0] win_lo, win_hi, seg_size, seg_lo;
    logic              win_hit, seg_hit_raw, seg_on, win_dram;
    logic [ADDR_W-1:0] seg_table [SEG_STEPS];

    assign win_lo = ext[7] ? ALIAS_BASE : LEGACY_BASE;
    assign win_hi = ext[7] ? (ALIAS_BASE + ALIAS_SIZE) : (LEGACY_BASE + LEGACY_SIZE);

    smram_window #(.ADDR_W(ADDR_W)) u_win (
        .addr(addr), .lo(win_lo), .hi(win_hi), .hit(win_hit)
    );

    for (genvar g = 0; g < SEG_STEPS; g++) begin : g_seg
        assign seg_table[g] = SEG_UNIT << g;
    end

    assign seg_size = seg_table[ext[SEL_W:1]];
    assign seg_lo   = (top > seg_size) ? (top - seg_size) : '0;
    assign seg_on   = ctrl[C_EN] && ext[0];

    smram_window #(.ADDR_W(ADDR_W)) u_seg (
        .addr(addr), .lo(seg_lo), .hi(top), .hit(seg_hit_raw)
    );

    always_comb begin
        if (smm) begin
            win_dram = ctrl[C_EN] && !ctrl[C_CLOSE];
        end else begin
            win_dram = (ctrl[C_OPEN:C_LOCK] == 3'b100);
        end
    end

    always_comb begin
        if (win_hit) begin
            to_dram = win_dram;
        end else if (seg_on && seg_hit_raw) begin
            to_dram = smm;
        end else begin
            to_dram = (addr < top);
        end
    end

endmodule

// File: rtl/smram_gate.sv
module smram_gate
    import smram_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              smm_mode,
    input  logic [ADDR_W-1:0] tom,
    output logic              route_dram
);

    logic [REG_W-1:0] ctrl_q, ext_q;

    smram_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_off(cfg_addr),
        .wr_data(cfg_wdata), .rd_data(cfg_rdata), .ctrl_q(ctrl_q), .ext_q(ext_q)
    );

    smram_route #(.ADDR_W(ADDR_W)) u_route (
        .addr(acc_addr), .smm(smm_mode), .top(tom),
        .ctrl(ctrl_q), .ext(ext_q), .to_dram(route_dram)
    );

endmodule

// File: rtl/smram_gate_chk.sv
module smram_gate_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        ctrl_q,
    input logic [7:0]        ext_q,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              smm_mode,
    input logic              route_dram
);

    logic in_legacy;
    assign in_legacy = (acc_addr >= 32'h000A_0000) && (acc_addr < 32'h000C_0000) && !ext_q[7];

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_q[4]) |-> ctrl_q[4]) else $error("lock dropped"); // R3

    AST_LOCK_CLEARS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[4]) |-> !ctrl_q[6]) else $error("open survived lock"); // R3

    AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_q[4]) && ctrl_q[4]) |-> ($stable(ctrl_q[7:6]) && $stable(ctrl_q[4:0])))
        else $error("locked ctrl changed"); // R4

    AST_LOCKED_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_q[4]) && ctrl_q[4]) |-> ($stable(ext_q[7:6]) && $stable(ext_q[2:0])))
        else $error("locked ext changed"); // R9

    AST_WINDOW_CLOSED_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smm_mode && in_legacy && ctrl_q[6:4] != 3'b100) |-> !route_dram)
        else $error("window leaked outside smm"); // R5

    AST_WINDOW_SMM: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_mode && in_legacy) |-> (route_dram == (ctrl_q[3] && !ctrl_q[5])))
        else $error("smm window route"); // R6

endmodule

bind smram_gate smram_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q), .ext_q(ext_q),
    .acc_addr(acc_addr), .smm_mode(smm_mode), .route_dram(route_dram)
);

// File: tb/smram_gate_bench.sv
module smram_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [31:0] acc_addr = 32'h0;
    logic        smm_mode = 1'b0;
    logic [31:0] tom = 32'h0100_0000;
    logic        route_dram;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    smram_gate u_smram_gate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
        .smm_mode(smm_mode), .tom(tom), .route_dram(route_dram)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] off, logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = off; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] off, logic [7:0] exp);
        cfg_addr = off;
        #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic route_check(string req, logic [31:0] a, logic smm, logic exp);
        acc_addr = a; smm_mode = smm;
        #1;
        check(req, {31'h0, route_dram}, {31'h0, exp});
    endtask

    task automatic t_reset();
        do_reset();
        rd_check("R1 ctrl reset", 8'h72, 8'h02);
        rd_check("R1 ext reset", 8'h73, 8'h00);
        route_check("R1 legacy ext bus", 32'h000A_0000, 1'b0, 1'b0);
    endtask

    task automatic t_unlocked();
        do_reset();
        wr(8'h72, 8'h68);
        rd_check("R2 write 68", 8'h72, 8'h6A);
        wr(8'h72, 8'h87);
        rd_check("R2 write 87", 8'h72, 8'h02);
        wr(8'h70, 8'hFF);
        rd_check("R11 ctrl after other offset", 8'h72, 8'h02);
        rd_check("R11 ext after other offset", 8'h73, 8'h00);
        rd_check("R11 other offset reads 0", 8'h70, 8'h00);
    endtask

    task automatic t_window_outside();
        do_reset();
        wr(8'h72, 8'h48);
        route_check("R5 open+en dram", 32'h000B_FFFF, 1'b0, 1'b1);
        wr(8'h72, 8'h60);
        route_check("R5 open+close ext", 32'h000A_0000, 1'b0, 1'b0);
        route_check("R10 above window", 32'h000C_0000, 1'b0, 1'b1);
    endtask

    task automatic t_window_smm();
        do_reset();
        wr(8'h72, 8'h08);
        route_check("R6 smm en dram", 32'h000A_8000, 1'b1, 1'b1);
        route_check("R5 non-smm en only ext", 32'h000A_8000, 1'b0, 1'b0);
        wr(8'h72, 8'h28);
        route_check("R6 smm close ext", 32'h000A_8000, 1'b1, 1'b0);
        wr(8'h72, 8'h00);
        route_check("R6 smm disabled ext", 32'h000A_8000, 1'b1, 1'b0);
    endtask

    task automatic t_lock();
        do_reset();
        wr(8'h72, 8'hFF);
        rd_check("R3 lock clears open", 8'h72, 8'h3A);
        wr(8'h72, 8'h40);
        rd_check("R4 locked write 40", 8'h72, 8'h1A);
        wr(8'h72, 8'h20);
        rd_check("R4 locked close set", 8'h72, 8'h3A);
    endtask

    task automatic t_ext_lock();
        do_reset();
        wr(8'h73, 8'h05);
        rd_check("R9 ext stores", 8'h73, 8'h05);
        wr(8'h72, 8'h18);
        rd_check("R3 lock write 18", 8'h72, 8'h1A);
        rd_check("R9 ext mirror", 8'h73, 8'h1D);
        wr(8'h73, 8'hC2);
        rd_check("R9 ext ignored locked", 8'h73, 8'h1D);
        wr(8'h72, 8'h20);
        rd_check("R9 ext mirror close", 8'h73, 8'h3D);
        wr(8'h72, 8'h00);
        rd_check("R4 close cleared, en kept", 8'h72, 8'h1A);
    endtask

    task automatic t_alias();
        do_reset();
        wr(8'h73, 8'h80);
        wr(8'h72, 8'h40);
        route_check("R7 alias low dram", 32'h100A_0000, 1'b0, 1'b1);
        route_check("R7 alias high dram", 32'h100F_FFFF, 1'b0, 1'b1);
        route_check("R7 past alias ext", 32'h1010_0000, 1'b0, 1'b0);
        wr(8'h72, 8'h00);
        route_check("R7 alias closed", 32'h100A_0000, 1'b0, 1'b0);
        route_check("R7 legacy default", 32'h000A_0000, 1'b0, 1'b1);
    endtask

    task automatic t_segment();
        do_reset();
        tom = 32'h0100_0000;
        wr(8'h72, 8'h08);
        wr(8'h73, 8'h05);
        route_check("R8 seg base smm", 32'h00F8_0000, 1'b1, 1'b1);
        route_check("R8 seg base non-smm", 32'h00F8_0000, 1'b0, 1'b0);
        route_check("R8 below seg", 32'h00F7_FFFF, 1'b0, 1'b1);
        route_check("R10 at tom", 32'h0100_0000, 1'b0, 1'b0);
        wr(8'h73, 8'h07);
        route_check("R8 1MB seg non-smm", 32'h00F0_0000, 1'b0, 1'b0);
        wr(8'h73, 8'h01);
        route_check("R8 128K seg outside", 32'h00FD_FFFF, 1'b0, 1'b1);
        route_check("R8 128K seg inside", 32'h00FE_0000, 1'b0, 1'b0);
        wr(8'h73, 8'h00);
        route_check("R8 seg disabled", 32'h00FE_0000, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_unlocked();
        t_window_outside();
        t_window_smm();
        t_lock();
        t_ext_lock();
        t_alias();
        t_segment();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule